// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block produces the command, address and clock-enable pins of an SDRAM with a 4-bit data bus for one burst of byte reads. A host gives a bank, a row, a starting column and a byte count. The block closes all banks and opens the requested row. It then reads one column per nibble. After each nibble is sampled, it stalls the memory clock. Every two nibbles are put back together into a byte, which is handed to the host with a one-cycle strobe.

Three programmable gaps set the spacing of commands:
- the wait between the opening bank-close and the first row open;
- the wait between a mid-burst bank-close and the reopen;
- the wait between a row open and the first read.

When the column counter runs past the last column of a page, the block performs a close, wait, reopen and wait sequence on the next row, without host involvement. After that it continues reading from column 0. The bank stays the same for the whole burst.

A build parameter selects CAS latency (2 or 3). Another selects a 1x or 2x controller clock, which sets the clock-stall length (1 or 2 cycles). The page size comes from the column width parameter.

Top module: `sdram_burst_reader`

## Requirements
- R1: While reset is held and after it is released, the block is idle with these outputs: `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` all 1; `sd_cke` 1; `sd_dqm` 1; `sd_ba` and `sd_a` 0; `req_ready` 1; `rd_valid` and `rd_done` 0.
- R2: `req_ready` is 1 only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. A `req_valid` raised during a burst has no effect on any output.
- R3: In the cycle after a request with nonzero length is taken, the command is bank-close-all. Its encoding is CS, RAS and WE low with CAS high, and `sd_a` = 0x400 (A10 high).
- R4: The bank-close-all is followed by `cfg_first_gap`+1 NOP cycles. The NOP encoding is CS low with RAS, CAS and WE high. After these comes one row-open command: CS and RAS low, CAS and WE high, `sd_ba` = the bank and `sd_a` = the row.
- R5: Each row-open is followed by `cfg_act_rd_gap` NOP cycles (0 to 7) and then a read command. The read encoding is CS and CAS low with RAS and WE high, and `sd_a` = the column.
- R6: With CAS latency 3, every read is followed by exactly one extra NOP before the sample cycle. With CAS latency 2, the sample cycle comes directly after the read.
- R7: After each sample cycle, `sd_cke` is low for 1 cycle (1x clock) or 2 cycles (2x clock), with a NOP command. `sd_cke` is high in every other cycle.
- R8: Nibbles are captured from `sd_dq` at the end of each sample cycle. The first nibble of a byte is bits 3:0 and the second is bits 7:4. `rd_valid` is 1 for one cycle, with `rd_byte`, in the cycle after the second sample.
- R9: Inside one page, successive reads carry columns that increase by one, with no close or open command between them.
- R10: After a read of the last column of a page, if more nibbles remain, the block issues in order: bank-close-all with `sd_a` = 0x400; `cfg_reopen_gap` NOPs (0 allowed); a row-open of row+1 (wrapping modulo the row range); `cfg_act_rd_gap` NOPs; a read of column 0.
- R11: `rd_done` is 1 for one cycle, in the cycle after the last clock-stall of the burst. The next cycle is idle. A request of length 0 gives `rd_done` in the cycle after it is taken, with no command issued.
- R12: `sd_dqm` is low in every cycle from the first bank-close through the last clock-stall. It is high when idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | High while idle and able to take a request |
| req_bank | input | BANK_W | Bank for the whole burst |
| req_row | input | ROW_W | Starting row |
| req_col | input | COL_W | Starting column |
| req_len | input | CNT_W | Number of bytes to read |
| cfg_first_gap | input | 2 | NOPs minus one between the first close and the open |
| cfg_reopen_gap | input | 2 | NOPs between a page-crossing close and the reopen |
| cfg_act_rd_gap | input | 3 | NOPs between a row open and the first read |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable; low stalls the memory clock |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | ADDR_W | Multiplexed row/column address |
| sd_dq | input | DQ_W | Read data nibble |
| rd_valid | output | 1 | One-cycle strobe for an assembled byte |
| rd_byte | output | WORD_W | Assembled byte |
| rd_done | output | 1 | One-cycle strobe at the end of the burst |

## Verification
The gap inputs are assumed to stay constant for the whole burst. The stall length is assumed to be at least one cycle, so two sample cycles are never adjacent. The single-cycle `rd_valid` check relies on this.

The stimulus changes the gap settings only between bursts. It changes the request fields during a burst only in the test that checks they are ignored. It uses a small page so that page crossings come early, including one where a byte is split across two rows and one at the last row.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_PGAP,
      ST_ACT,
      ST_RCGAP,
      ST_READ,
      ST_CLNOP,
      ST_SAMPLE,
      ST_SUSP,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_DESEL = 4'b1111;
   localparam sd_cmd_t CMD_NOP   = 4'b0111;
   localparam sd_cmd_t CMD_PRE   = 4'b0010;
   localparam sd_cmd_t CMD_ACT   = 4'b0011;
   localparam sd_cmd_t CMD_READ  = 4'b0101;

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign last = (cnt_q == W'(1));

   AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/sdr_col_walker.sv
module sdr_col_walker #(
   parameter int ROW_W = 12,
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] row_in,
   input  logic [COL_W-1:0] col_in,
   input  logic             step,
   input  logic             clr_wrap,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col,
   output logic             wrap_pend
);

   localparam logic [COL_W-1:0] COL_LAST = '1;

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             wrap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         wrap_q <= 1'b0;
      end else if (load) begin
         row_q  <= row_in;
         col_q  <= col_in;
         wrap_q <= 1'b0;
      end else if (step) begin
         if (col_q == COL_LAST) begin
            col_q  <= '0;
            row_q  <= row_q + ROW_W'(1);
            wrap_q <= 1'b1;
         end else begin
            col_q  <= col_q + COL_W'(1);
         end
      end else if (clr_wrap) begin
         wrap_q <= 1'b0;
      end
   end

   assign row       = row_q;
   assign col       = col_q;
   assign wrap_pend = wrap_q;

   AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (col_q == '0)); // R10

endmodule

// File: rtl/sdr_nib_pack.sv
module sdr_nib_pack #(
   parameter int DQ_W   = 4,
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp,
   input  logic [DQ_W-1:0]   dq,
   output logic              valid,
   output logic [WORD_W-1:0] word
);

   localparam int NIBS = WORD_W / DQ_W;
   localparam int PH_W = (NIBS > 1) ? $clog2(NIBS) : 1;
   localparam int LO_W = WORD_W - DQ_W;

   logic [PH_W-1:0]   phase_q;
   logic [LO_W-1:0]   low_w;
   logic [WORD_W-1:0] word_q;
   logic              valid_q;
   logic              top_nib;

   assign top_nib = (phase_q == PH_W'(NIBS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         phase_q <= '0;
      else if (smp)
         phase_q <= top_nib ? '0 : phase_q + PH_W'(1);
   end

   for (genvar i = 0; i < NIBS - 1; i++) begin : g_lane
      logic [DQ_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (smp && phase_q == PH_W'(i))
            q <= dq;
      end
      assign low_w[i*DQ_W +: DQ_W] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= smp && top_nib && !clr;
         if (smp && top_nib)
            word_q <= {dq, low_w};
      end
   end

   assign valid = valid_q;
   assign word  = word_q;

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q); // R8

endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
   import sdr_rd_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int ADDR_W    = 12,
   parameter int DQ_W      = 4,
   parameter int WORD_W    = 8,
   parameter int CNT_W     = 8,
   parameter int CAS_LAT   = 2,
   parameter int CLK_RATIO = 1,
   parameter int GAP_W     = 3,
   parameter int PRE_BIT   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [CNT_W-1:0]  req_len,
   input  logic [1:0]        cfg_first_gap,
   input  logic [1:0]        cfg_reopen_gap,
   input  logic [2:0]        cfg_act_rd_gap,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic              sd_dqm,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_a,
   input  logic [DQ_W-1:0]   sd_dq,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_byte,
   output logic              rd_done
);

   localparam int NIBS     = WORD_W / DQ_W;
   localparam int REM_W    = CNT_W + $clog2(NIBS);
   localparam int SUSP_CYC = (CLK_RATIO == 2) ? 2 : 1;
   localparam bit CL_NOP   = (CAS_LAT == 3);
   localparam logic [ADDR_W-1:0] PRE_ALL_A = ADDR_W'(1) << PRE_BIT;

   // elaboration-time parameter checks
   if (ROW_W > ADDR_W) begin : g_bad_row
      $error("ROW_W must not exceed ADDR_W");
   end
   if (COL_W >= PRE_BIT) begin : g_bad_col
      $error("column field must stay below the close-all bit");
   end
   if (PRE_BIT >= ADDR_W) begin : g_bad_pre
      $error("close-all bit outside the address bus");
   end
   if ((WORD_W % DQ_W) != 0 || NIBS < 2) begin : g_bad_word
      $error("WORD_W must be at least two whole nibbles");
   end
   if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
      $error("CAS_LAT must be 1, 2 or 3");
   end
   if (CLK_RATIO != 1 && CLK_RATIO != 2) begin : g_bad_ratio
      $error("CLK_RATIO must be 1 or 2");
   end
   if (GAP_W < 3) begin : g_bad_gap
      $error("GAP_W must hold the widest gap");
   end

   seq_state_e        state_q, state_d;
   logic [BANK_W-1:0] bank_q;
   logic [REM_W-1:0]  rem_q;
   logic              reopen_q;
   logic              accept;
   logic              tmr_load;
   logic [GAP_W-1:0]  tmr_val;
   logic              tmr_last;
   logic [GAP_W-1:0]  pre_gap;
   logic [GAP_W-1:0]  rc_gap;
   logic [ROW_W-1:0]  cur_row;
   logic [COL_W-1:0]  cur_col;
   logic              wrap_pend;
   logic              sample_now;
   sd_cmd_t           cmd;

   assign accept     = req_valid && (state_q == ST_IDLE);
   assign sample_now = (state_q == ST_SAMPLE);
   assign pre_gap    = reopen_q ? GAP_W'(cfg_reopen_gap)
                                : GAP_W'(cfg_first_gap) + GAP_W'(1);
   assign rc_gap     = GAP_W'(cfg_act_rd_gap);

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE:
            if (accept)
               state_d = (req_len == '0) ? ST_DONE : ST_PRE;
         ST_PRE:
            if (pre_gap == '0)
               state_d = ST_ACT;
            else begin
               state_d  = ST_PGAP;
               tmr_load = 1'b1;
               tmr_val  = pre_gap;
            end
         ST_PGAP:
            if (tmr_last)
               state_d = ST_ACT;
         ST_ACT:
            if (rc_gap == '0)
               state_d = ST_READ;
            else begin
               state_d  = ST_RCGAP;
               tmr_load = 1'b1;
               tmr_val  = rc_gap;
            end
         ST_RCGAP:
            if (tmr_last)
               state_d = ST_READ;
         ST_READ:
            state_d = CL_NOP ? ST_CLNOP : ST_SAMPLE;
         ST_CLNOP:
            state_d = ST_SAMPLE;
         ST_SAMPLE: begin
            state_d  = ST_SUSP;
            tmr_load = 1'b1;
            tmr_val  = GAP_W'(SUSP_CYC);
         end
         ST_SUSP:
            if (tmr_last) begin
               if (rem_q == '0)
                  state_d = ST_DONE;
               else if (wrap_pend)
                  state_d = ST_PRE;
               else
                  state_d = ST_READ;
            end
         ST_DONE:
            state_d = ST_IDLE;
         default:
            state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bank_q   <= '0;
         rem_q    <= '0;
         reopen_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            bank_q   <= req_bank;
            rem_q    <= REM_W'(req_len) * REM_W'(NIBS);
            reopen_q <= 1'b0;
         end else begin
            if (sample_now)
               rem_q <= rem_q - REM_W'(1);
            if (state_q == ST_SUSP && tmr_last && wrap_pend)
               reopen_q <= 1'b1;
         end
      end
   end

   sdr_gap_timer #(.W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   sdr_col_walker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .row_in    (req_row),
      .col_in    (req_col),
      .step      (state_q == ST_READ),
      .clr_wrap  (state_q == ST_ACT),
      .row       (cur_row),
      .col       (cur_col),
      .wrap_pend (wrap_pend)
   );

   sdr_nib_pack #(.DQ_W(DQ_W), .WORD_W(WORD_W)) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .smp   (sample_now),
      .dq    (sd_dq),
      .valid (rd_valid),
      .word  (rd_byte)
   );

   always_comb begin
      cmd    = CMD_NOP;
      sd_cke = 1'b1;
      sd_dqm = 1'b0;
      sd_ba  = bank_q;
      sd_a   = '0;
      case (state_q)
         ST_IDLE, ST_DONE: begin
            cmd    = CMD_DESEL;
            sd_dqm = 1'b1;
            sd_ba  = '0;
         end
         ST_PRE: begin
            cmd  = CMD_PRE;
            sd_a = PRE_ALL_A;
         end
         ST_ACT: begin
            cmd  = CMD_ACT;
            sd_a = ADDR_W'(cur_row);
         end
         ST_READ: begin
            cmd  = CMD_READ;
            sd_a = ADDR_W'(cur_col);
         end
         ST_SUSP:
            sd_cke = 1'b0;
         default: ;
      endcase
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign req_ready = (state_q == ST_IDLE);
   assign rd_done   = (state_q == ST_DONE);

   AST_STALL_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cke |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R7

   AST_CLOSE_ALL_A10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> (sd_a == PRE_ALL_A)); // R3

   AST_READ_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n)
      |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R6

   AST_DQM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !rd_done) |-> !sd_dqm); // R12

   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> (req_ready && !rd_done)); // R11

   AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> req_ready); // R2

endmodule

// File: tb/sim_sdram_burst_reader.sv
module sim_sdram_burst_reader;

   localparam int CLK_PERIOD = 10;
   localparam int COL_W      = 3;
   localparam int PAGE       = 1 << COL_W;
   localparam int CL         = 3;
   localparam int RATIO      = 2;
   localparam int SUSP_N     = 2;
   localparam int WDOG       = 20000;

   typedef struct {
      logic [3:0]  cmd;
      logic        cke;
      logic        dqm;
      logic        rdy;
      logic        done;
      logic        vld;
      logic [1:0]  ba;
      logic [11:0] a;
      logic [7:0]  byt;
      logic [3:0]  dq;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_bank = '0;
   logic [11:0] req_row = '0;
   logic [COL_W-1:0] req_col = '0;
   logic [5:0]  req_len = '0;
   logic [1:0]  cfg_first_gap = '0;
   logic [1:0]  cfg_reopen_gap = '0;
   logic [2:0]  cfg_act_rd_gap = '0;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm;
   logic [1:0]  sd_ba;
   logic [11:0] sd_a;
   logic [3:0]  sd_dq = 4'h5;
   logic        rd_valid, rd_done;
   logic [7:0]  rd_byte;

   int checks = 0;
   int failures = 0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_burst_reader #(
      .BANK_W(2), .ROW_W(12), .COL_W(COL_W), .ADDR_W(12), .DQ_W(4),
      .WORD_W(8), .CNT_W(6), .CAS_LAT(CL), .CLK_RATIO(RATIO),
      .GAP_W(3), .PRE_BIT(10)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_len(req_len), .cfg_first_gap(cfg_first_gap),
      .cfg_reopen_gap(cfg_reopen_gap), .cfg_act_rd_gap(cfg_act_rd_gap),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_ba(sd_ba),
      .sd_a(sd_a), .sd_dq(sd_dq), .rd_valid(rd_valid), .rd_byte(rd_byte),
      .rd_done(rd_done)
   );

   function automatic logic [3:0] mem_nib(int row, int col);
      return 4'((row * 5 + col * 3 + 1) & 15);
   endfunction

   task automatic chk(string rq, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic exp_t ent(logic [3:0] cmd, logic [1:0] ba, logic [11:0] a, string tag);
      exp_t e;
      e.cmd = cmd; e.cke = 1'b1; e.dqm = 1'b0; e.rdy = 1'b0; e.done = 1'b0;
      e.vld = 1'b0; e.ba = ba; e.a = a; e.byt = '0; e.dq = 4'h9; e.tag = tag;
      return e;
   endfunction

   task automatic build(int bank, int row, int col, int len, int fg, int rg, int rc);
      exp_t e;
      int r, c;
      logic [3:0] lo, nib;
      q.delete();
      if (len > 0) begin
         q.push_back(ent(4'b0010, 2'(bank), 12'h400, "R3"));
         for (int k = 0; k < fg + 1; k++) q.push_back(ent(4'b0111, 2'(bank), 12'h0, "R4"));
         q.push_back(ent(4'b0011, 2'(bank), 12'(row), "R4"));
         for (int k = 0; k < rc; k++) q.push_back(ent(4'b0111, 2'(bank), 12'h0, "R5"));
         r = row; c = col; lo = '0;
         for (int i = 0; i < 2 * len; i++) begin
            q.push_back(ent(4'b0101, 2'(bank), 12'(c), "R9"));
            if (CL == 3) q.push_back(ent(4'b0111, 2'(bank), 12'h0, "R6"));
            nib = mem_nib(r, c);
            e = ent(4'b0111, 2'(bank), 12'h0, "R8");
            e.dq = nib;
            q.push_back(e);
            for (int s = 0; s < SUSP_N; s++) begin
               e = ent(4'b0111, 2'(bank), 12'h0, "R7");
               e.cke = 1'b0;
               if (s == 0 && (i % 2) == 1) begin
                  e.vld = 1'b1;
                  e.byt = {nib, lo};
               end
               q.push_back(e);
            end
            if ((i % 2) == 0) lo = nib;
            if (c == PAGE - 1) begin
               c = 0;
               r = (r + 1) % 4096;
               if (i < 2 * len - 1) begin
                  q.push_back(ent(4'b0010, 2'(bank), 12'h400, "R10"));
                  for (int k = 0; k < rg; k++) q.push_back(ent(4'b0111, 2'(bank), 12'h0, "R10"));
                  q.push_back(ent(4'b0011, 2'(bank), 12'(r), "R10"));
                  for (int k = 0; k < rc; k++) q.push_back(ent(4'b0111, 2'(bank), 12'h0, "R10"));
               end
            end else begin
               c = c + 1;
            end
         end
      end
      e = ent(4'b1111, 2'b00, 12'h0, "R11");
      e.dqm = 1'b1; e.done = 1'b1;
      q.push_back(e);
      e = ent(4'b1111, 2'b00, 12'h0, "R11");
      e.dqm = 1'b1; e.rdy = 1'b1;
      q.push_back(e);
   endtask

   task automatic cmp(exp_t e);
      chk(e.tag, "cmd", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e.cmd));
      chk(e.tag, "cke", int'(sd_cke), int'(e.cke));
      chk(e.tag, "ba", int'(sd_ba), int'(e.ba));
      chk(e.tag, "a", int'(sd_a), int'(e.a));
      chk("R12", "dqm", int'(sd_dqm), int'(e.dqm));
      chk("R2", "req_ready", int'(req_ready), int'(e.rdy));
      chk("R8", "rd_valid", int'(rd_valid), int'(e.vld));
      if (e.vld) chk("R8", "rd_byte", int'(rd_byte), int'(e.byt));
      chk("R11", "rd_done", int'(rd_done), int'(e.done));
   endtask

   task automatic run(int bank, int row, int col, int len, int fg, int rg, int rc, bit noise);
      @(negedge clk);
      cfg_first_gap = 2'(fg); cfg_reopen_gap = 2'(rg); cfg_act_rd_gap = 3'(rc);
      req_bank = 2'(bank); req_row = 12'(row); req_col = COL_W'(col); req_len = 6'(len);
      req_valid = 1'b1;
      chk("R2", "ready before request", int'(req_ready), 1);
      build(bank, row, col, len, fg, rg, rc);
      for (int k = 0; k < q.size(); k++) begin
         @(negedge clk);
         if (k == 0) begin
            req_valid = noise;
            req_bank = 2'(bank + 1); req_row = 12'(row + 9);
            req_col = COL_W'(col + 2); req_len = 6'(len + 3);
         end
         if (q[k].done || q[k].rdy) req_valid = 1'b0;
         sd_dq = q[k].dq;
         cmp(q[k]);
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "cmd in reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 15);
      chk("R1", "ready in reset", int'(req_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cke after reset", int'(sd_cke), 1);
      chk("R1", "dqm after reset", int'(sd_dqm), 1);
      chk("R1", "a after reset", int'(sd_a), 0);
      chk("R1", "ba after reset", int'(sd_ba), 0);
      chk("R1", "valid/done after reset", int'({rd_valid, rd_done}), 0);
      // R9: within one page
      run(1, 5, 0, 2, 0, 1, 1, 1'b0);
      // R10: crossing with zero reopen gap and zero open-to-read gap
      run(2, 40, 6, 3, 3, 0, 0, 1'b0);
      // R10: byte split across rows, last row wraps to row 0
      run(3, 4095, 7, 2, 1, 2, 7, 1'b0);
      // R11: zero-length request
      run(0, 3, 2, 0, 0, 0, 0, 1'b0);
      // R2: request held high during a burst is ignored
      run(1, 100, 4, 3, 2, 3, 2, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule